// File: doc/BRIEF.md
# Paired PWM Output Stage with Dead-Time Insertion

This block sits between a PWM compare unit and the output pins of a motor or power-stage driver. It takes the raw compare level of every channel and routes the channels as pairs: each pair (0/1, 2/3, 4/5 at the default size) runs independent, complementary or synchronized. A group option makes every even channel follow the timing of channel 0. In complementary pairs whose dead-time enable is set, the rising edge of each output is held back by a programmable number of clock cycles. During that gap both transistors of the half bridge are off, and any pulse no longer than the gap is removed.

After the pair logic, each channel passes through a fixed chain of overrides. First comes a software mask that replaces the generated level with a fixed bit. Next an external brake input forces a programmed safe level onto every channel. Polarity inversion is applied last. The final levels of channels 0, 2 and 4 are watched by edge detectors. Each detector sets a flag on a selectable edge, and the flag is cleared by a write-one pulse. The enabled flags are ORed into one interrupt line.

Top module: `pwm_pair_stage`

## Requirements
- R1: With pair mode 2'b00 (independent) or 2'b11 (reserved), every output channel n follows raw input n, before overrides.
- R2: With pair mode 2'b01 (complementary) and the pair's dead-time enable clear, the odd channel of each pair is the inverse of the even channel, with no clock delay, and the odd raw inputs are ignored.
- R3: With pair mode 2'b10 (synchronized), the odd channel of each pair equals the even channel, without inversion.
- R4: With the group bit set, the even channels of pairs 1 and above take raw input 0 in place of their own raw input, in every mode. Their odd partners derive from that level as the mode requires.
- R5: In complementary mode with the pair's dead-time enable set, a change of the even level drops the active output at once. The newly active output rises only after the dead-time count of clock edges, and both outputs stay low in between.
- R6: In complementary mode with dead time enabled, a level that holds for no more than the dead-time count of clock edges never appears on the outputs.
- R7: Dead-time insertion is bypassed for pairs whose enable is clear, and for all pairs in any mode other than complementary. The outputs then follow without delay.
- R8: For each channel n, a set mask-enable bit n replaces the generated level with mask-data bit n.
- R9: While the brake input is high, every channel takes its brake-level bit. This overrides the mask.
- R10: Each set polarity bit n inverts channel n as the last step, after the brake and mask overrides.
- R11: For even channels 0, 2 and 4, the flag of that channel is set one clock after its final output level shows a falling edge (edge-select bit 0) or a rising edge (edge-select bit 1). The edge of the other direction is ignored.
- R12: A high clear bit for a flag clears that flag on the next clock. A new edge in the same cycle wins over the clear.
- R13: The interrupt output is high exactly when some flag is set and its interrupt-enable bit is set.
- R14: After reset, all edge flags and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_cmp | input | 2*NPAIR | Raw compare level per channel |
| pair_mode | input | 2 | 0 independent, 1 complementary, 2 synchronized, 3 reserved (as 0) |
| group_en | input | 1 | Even channels follow channel 0 timing |
| dt_count | input | DT_W | Dead time in clock cycles |
| dt_en | input | NPAIR | Dead-time enable per pair |
| mask_en | input | 2*NPAIR | Mask override enable per channel |
| mask_val | input | 2*NPAIR | Mask level per channel |
| brake_act | input | 1 | Brake request, forces brake levels |
| brake_lvl | input | 2*NPAIR | Level per channel during brake |
| pol_neg | input | 2*NPAIR | Output inversion per channel |
| edge_rise_sel | input | NPAIR | Per even channel: 1 rising, 0 falling edge sets the flag |
| edge_ie | input | NPAIR | Interrupt enable per flag |
| flag_clr | input | NPAIR | Write-one clear pulse per flag |
| pwm_out | output | 2*NPAIR | Final pin levels |
| edge_flag | output | NPAIR | Edge flags of channels 0, 2, 4, ... |
| edge_irq | output | 1 | OR of enabled flags |

## Verification
The bench builds the block with three pairs and a dead-time width of 4 bits. With a 4-bit count the full-scale dead time of 15 cycles is reached within a short run, so the bench can count the delay at the counter's top value as well as at a small value. Three pairs let one pair run with dead time while a neighbour bypasses it, and let the group option reroute two even channels at once.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   typedef enum logic [1:0] {
      PM_INDEP = 2'd0,
      PM_COMP  = 2'd1,
      PM_SYNC  = 2'd2,
      PM_RSVD  = 2'd3
   } pair_mode_e;
endpackage

// File: rtl/pwm_pair_route.sv
module pwm_pair_route
   import pwm_pair_pkg::*;
#(
   parameter int NPAIR = 3,
   localparam int NCH  = 2 * NPAIR
) (
   input  logic [NCH-1:0]   raw_i,
   input  logic [1:0]       mode_i,
   input  logic             group_i,
   output logic [NPAIR-1:0] even_o,
   output logic [NPAIR-1:0] odd_o,
   output logic             comp_o
);
   pair_mode_e mode;
   assign mode   = pair_mode_e'(mode_i);
   assign comp_o = (mode == PM_COMP);

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic ev;
      if (p == 0) begin : g_lead
         assign ev = raw_i[0];
      end else begin : g_follow
         assign ev = group_i ? raw_i[0] : raw_i[2*p];
      end
      assign even_o[p] = ev;
      always_comb begin
         unique case (mode)
            PM_COMP: odd_o[p] = ~ev;
            PM_SYNC: odd_o[p] = ev;
            default: odd_o[p] = raw_i[2*p+1];
         endcase
      end
   end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
   parameter int DT_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active_i,
   input  logic [DT_W-1:0] dt_cnt_i,
   input  logic            even_i,
   input  logic            odd_i,
   output logic            even_o,
   output logic            odd_o
);
   logic            lvl_q;
   logic [DT_W-1:0] cnt_q;
   logic            settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else if (even_i != lvl_q) begin
         lvl_q <= even_i;
         cnt_q <= dt_cnt_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - DT_W'(1);
      end
   end

   assign settled = (even_i == lvl_q) && (cnt_q == '0);

   always_comb begin
      if (active_i) begin
         even_o = settled & even_i;
         odd_o  = settled & ~even_i;
      end else begin
         even_o = even_i;
         odd_o  = odd_i;
      end
   end

   // R5
   dt_rise_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && even_o && dt_cnt_i != '0 && $stable(dt_cnt_i)) |-> $past(even_i));
   // R6
   dt_odd_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && odd_o && dt_cnt_i != '0 && $stable(dt_cnt_i)) |-> !$past(even_i));
endmodule

// File: rtl/pwm_out_ovr.sv
module pwm_out_ovr #(
   parameter int NCH = 6
) (
   input  logic [NCH-1:0] gen_i,
   input  logic [NCH-1:0] mask_en_i,
   input  logic [NCH-1:0] mask_val_i,
   input  logic           brake_i,
   input  logic [NCH-1:0] brake_lvl_i,
   input  logic [NCH-1:0] pol_i,
   output logic [NCH-1:0] pin_o
);
   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic masked, braked;
      assign masked   = mask_en_i[n] ? mask_val_i[n] : gen_i[n];
      assign braked   = brake_i ? brake_lvl_i[n] : masked;
      assign pin_o[n] = braked ^ pol_i[n];
   end
endmodule

// File: rtl/pwm_edge_flag.sv
module pwm_edge_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_sel_i,
   input  logic clr_i,
   output logic flag_o
);
   logic prev_q, hit;

   assign hit = rise_sel_i ? (pin_i & ~prev_q) : (~pin_i & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         prev_q <= pin_i;
         if (hit)        flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   // R11
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_sel_i && pin_i && !$past(pin_i)) |=> flag_o);
   // R12
   edge_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
   import pwm_pair_pkg::*;
#(
   parameter int NPAIR = 3,
   parameter int DT_W  = 11,
   localparam int NCH  = 2 * NPAIR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   raw_cmp,
   input  logic [1:0]       pair_mode,
   input  logic             group_en,
   input  logic [DT_W-1:0]  dt_count,
   input  logic [NPAIR-1:0] dt_en,
   input  logic [NCH-1:0]   mask_en,
   input  logic [NCH-1:0]   mask_val,
   input  logic             brake_act,
   input  logic [NCH-1:0]   brake_lvl,
   input  logic [NCH-1:0]   pol_neg,
   input  logic [NPAIR-1:0] edge_rise_sel,
   input  logic [NPAIR-1:0] edge_ie,
   input  logic [NPAIR-1:0] flag_clr,
   output logic [NCH-1:0]   pwm_out,
   output logic [NPAIR-1:0] edge_flag,
   output logic             edge_irq
);
   initial begin
      assert (NPAIR >= 1 && NPAIR <= 16);
      assert (DT_W >= 1 && DT_W <= 16);
   end

   logic [NPAIR-1:0] ev_ref, od_ref;
   logic             comp_on;
   logic [NCH-1:0]   gen;

   pwm_pair_route #(.NPAIR(NPAIR)) u_route (
      .raw_i  (raw_cmp),
      .mode_i (pair_mode),
      .group_i(group_en),
      .even_o (ev_ref),
      .odd_o  (od_ref),
      .comp_o (comp_on)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_deadband #(.DT_W(DT_W)) u_db (
         .clk     (clk),
         .rst_n   (rst_n),
         .active_i(comp_on & dt_en[p]),
         .dt_cnt_i(dt_count),
         .even_i  (ev_ref[p]),
         .odd_i   (od_ref[p]),
         .even_o  (gen[2*p]),
         .odd_o   (gen[2*p+1])
      );
      pwm_edge_flag u_edge (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_i     (pwm_out[2*p]),
         .rise_sel_i(edge_rise_sel[p]),
         .clr_i     (flag_clr[p]),
         .flag_o    (edge_flag[p])
      );
   end

   pwm_out_ovr #(.NCH(NCH)) u_ovr (
      .gen_i      (gen),
      .mask_en_i  (mask_en),
      .mask_val_i (mask_val),
      .brake_i    (brake_act),
      .brake_lvl_i(brake_lvl),
      .pol_i      (pol_neg),
      .pin_o      (pwm_out)
   );

   assign edge_irq = |(edge_flag & edge_ie);

   // R9
   brake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brake_act |-> (pwm_out == (brake_lvl ^ pol_neg)));
   // R2
   comp_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_mode == PM_COMP && !dt_en[0] && mask_en[1:0] == 2'b00 && !brake_act
       && pol_neg[1:0] == 2'b00) |-> (pwm_out[1] == ~pwm_out[0]));
   // R13
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_irq |-> ((edge_flag & edge_ie) != '0));
endmodule

// File: tb/tb_pwm_pair_stage.sv
module tb_pwm_pair_stage;
   localparam int NPAIR = 3;
   localparam int DT_W  = 4;
   localparam int NCH   = 2 * NPAIR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]   raw_cmp = '0;
   logic [1:0]       pair_mode = 2'd0;
   logic             group_en = 1'b0;
   logic [DT_W-1:0]  dt_count = '0;
   logic [NPAIR-1:0] dt_en = '0;
   logic [NCH-1:0]   mask_en = '0, mask_val = '0, brake_lvl = '0, pol_neg = '0;
   logic             brake_act = 1'b0;
   logic [NPAIR-1:0] edge_rise_sel = '0, edge_ie = '0, flag_clr = '0;
   logic [NCH-1:0]   pwm_out;
   logic [NPAIR-1:0] edge_flag;
   logic             edge_irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pwm_pair_stage #(.NPAIR(NPAIR), .DT_W(DT_W)) dut (.*);

   // fields: mode grp msk_en msk_val brk brk_lvl pol raw exp
   localparam logic [39:0] VEC [12] = '{
      {2'd0,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b101101,6'b101101}, // R1
      {2'd0,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b010010,6'b010010}, // R1
      {2'd3,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b110001,6'b110001}, // R1
      {2'd1,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b011100,6'b010110}, // R2
      {2'd2,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b100101,6'b001111}, // R3
      {2'd1,1'b1,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b000001,6'b010101}, // R4
      {2'd0,1'b1,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b010100,6'b000000}, // R4
      {2'd0,1'b0,6'b000110,6'b000100,1'b0,6'b000000,6'b000000,6'b111111,6'b111101}, // R8
      {2'd0,1'b0,6'b111111,6'b000000,1'b1,6'b110011,6'b000000,6'b101010,6'b110011}, // R9
      {2'd0,1'b0,6'b000000,6'b000000,1'b0,6'b000000,6'b000101,6'b000011,6'b000110}, // R10
      {2'd0,1'b0,6'b000000,6'b000000,1'b1,6'b000001,6'b000011,6'b000000,6'b000010}, // R10
      {2'd2,1'b1,6'b000000,6'b000000,1'b0,6'b000000,6'b000000,6'b000001,6'b111111}  // R3 R4
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk("R14", {1'b0, edge_irq, pwm_out}, 8'b0);
      chk("R14", {5'b0, edge_flag}, 8'b0);

      for (int i = 0; i < 12; i++) begin
         pair_mode = VEC[i][39:38];
         group_en  = VEC[i][37];
         mask_en   = VEC[i][36:31];
         mask_val  = VEC[i][30:25];
         brake_act = VEC[i][24];
         brake_lvl = VEC[i][23:18];
         pol_neg   = VEC[i][17:12];
         raw_cmp   = VEC[i][11:6];
         @(negedge clk);
         chk($sformatf("vector %0d R1-group", i), {2'b0, pwm_out}, {2'b0, VEC[i][5:0]});
      end
      group_en = 0; mask_en = '0; brake_act = 0; pol_neg = '0;

      // R5 dead time of 3 on pair 0, pair 1 bypassed (R7)
      pair_mode = 2'd1; dt_en = 3'b001; dt_count = 4'd3; raw_cmp = '0;
      repeat (20) @(negedge clk);
      chk("R5", {6'b0, pwm_out[1:0]}, 8'b10);
      raw_cmp = 6'b000101;
      #1;
      chk("R5", {6'b0, pwm_out[1:0]}, 8'b00);
      chk("R7", {6'b0, pwm_out[3:2]}, 8'b01);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R5", {6'b0, pwm_out[1:0]}, 8'b00);
      end
      @(negedge clk);
      chk("R5", {6'b0, pwm_out[1:0]}, 8'b01);
      raw_cmp = 6'b000000;
      #1;
      chk("R5", {6'b0, pwm_out[1:0]}, 8'b00);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R5", {6'b0, pwm_out[1:0]}, 8'b00);
      end
      @(negedge clk);
      chk("R5", {6'b0, pwm_out[1:0]}, 8'b10);

      // R6 pulse equal to dead time is suppressed
      repeat (5) @(negedge clk);
      seen = 0;
      raw_cmp[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (pwm_out[0]) seen = 1;
      end
      raw_cmp[0] = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (pwm_out[0]) seen = 1;
      end
      chk("R6", {7'b0, seen}, 8'b0);

      // R5 full-scale dead time
      dt_count = 4'd15;
      repeat (20) @(negedge clk);
      raw_cmp[0] = 1'b1;
      n = 0;
      @(negedge clk);
      while (!pwm_out[0] && n < 40) begin
         n++;
         @(negedge clk);
      end
      chk("R5", 8'(n), 8'd15);

      // R7 synchronized mode bypasses dead time
      pair_mode = 2'd2; dt_en = 3'b111; raw_cmp = '0;
      repeat (20) @(negedge clk);
      raw_cmp[0] = 1'b1;
      #1;
      chk("R7", {6'b0, pwm_out[1:0]}, 8'b11);

      // R11 R12 R13 edge flags
      pair_mode = 2'd0; dt_en = '0; raw_cmp = '0;
      repeat (2) @(negedge clk);
      flag_clr = 3'b111;
      @(negedge clk);
      flag_clr = '0;
      chk("R12", {5'b0, edge_flag}, 8'b0);
      edge_rise_sel = 3'b001; edge_ie = 3'b001;
      raw_cmp = 6'b000101;
      @(negedge clk);
      chk("R11", {5'b0, edge_flag}, 8'b001);
      chk("R13", {7'b0, edge_irq}, 8'b1);
      raw_cmp = 6'b000001;
      @(negedge clk);
      chk("R11", {5'b0, edge_flag}, 8'b011);
      flag_clr = 3'b001;
      @(negedge clk);
      flag_clr = '0;
      chk("R12", {5'b0, edge_flag}, 8'b010);
      chk("R13", {7'b0, edge_irq}, 8'b0);
      raw_cmp = 6'b000000;
      @(negedge clk);
      chk("R11", {5'b0, edge_flag}, 8'b010);
      raw_cmp = 6'b000001; flag_clr = 3'b001;
      @(negedge clk);
      flag_clr = '0;
      chk("R12", {5'b0, edge_flag}, 8'b011);
      chk("R13", {7'b0, edge_irq}, 8'b1);

      finish_run();
   end
endmodule